// File: doc/BRIEF.md
# Register Rename Map with Free List

This block is the rename stage of an out-of-order core. It handles one instruction per cycle. It translates two architectural source register numbers into physical register tags. When the instruction writes a register, the block takes a fresh physical tag from a pool of unused tags and points the architectural destination at it. In the same step it reports the tag the destination held before, so that the reorder logic can keep it for rollback and free it at commit.

The block holds two stores:
- **Alias table:** one physical tag per architectural register.
- **Free list:** a circular queue of unused physical tags.

Commit logic hands tags back through the release port. Rollback logic rewrites single table entries through the restore port.

A two-state machine tracks the pool:
- **FLOWING:** the free list is non-empty. `in_ready` is high unless a restore is active.
- **STARVED:** the free list was empty at the start of the cycle. `in_ready` is low.

The transitions are:
- **DRAIN:** FLOWING to STARVED, when the level after the cycle's pop and push reaches zero.
- **REFILL:** STARVED to FLOWING, when a release arrives.
- **HOLD:** every other case keeps the current state.

The lookup outputs are combinational from the current table and the head of the free list. An instruction is accepted when `in_valid && in_ready`. Its table update and its pop from the free list take effect at that clock edge.

Top module: `rn_rename_map`

## Requirements
- R1: After reset, architectural register i maps to physical tag i. The free list holds tags NUM_ARCH to NUM_PHYS-1 in ascending order, and `in_ready` is high.
- R2: `out_src_a_tag` and `out_src_b_tag` equal the alias table entries of `in_src_a` and `in_src_b`.
- R3: An accepted instruction with `in_dst_en`=1 is given the tag at the head of the free list on `out_new_tag`. That tag is never equal to the destination's current mapping.
- R4: After an accepted instruction with a destination, the table entry of `in_dst` holds the new tag, and later lookups of that register return it.
- R5: `out_old_tag` equals the mapping of `in_dst` before the instruction is accepted.
- R6: An accepted instruction with `in_dst_en`=0 consumes no tag and leaves the table unchanged.
- R7: When the free list is empty, `in_ready` is low and no instruction is accepted or applied. Released tags join the tail of the free list and are handed out in release order.
- R8: A release and an allocation in the same cycle are both honoured. A stall is raised only if the list was empty before that cycle's release.
- R9: A restore (`fix_valid`=1) writes `fix_tag` into entry `fix_arch`. `in_ready` is low during that cycle, and the rename in that cycle is not applied.
- R10: A source that names the same register as the destination of the same instruction returns the mapping from before that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_src_a | input | AW | Architectural source A |
| in_src_b | input | AW | Architectural source B |
| in_dst_en | input | 1 | Instruction writes a destination |
| in_dst | input | AW | Architectural destination |
| in_ready | output | 1 | Instruction accepted this cycle when valid |
| out_src_a_tag | output | TW | Physical tag of source A |
| out_src_b_tag | output | TW | Physical tag of source B |
| out_new_tag | output | TW | Tag allocated for the destination |
| out_old_tag | output | TW | Previous tag of the destination |
| free_valid | input | 1 | Release a tag to the free list |
| free_tag | input | TW | Tag being released |
| fix_valid | input | 1 | Restore write to the alias table |
| fix_arch | input | AW | Entry to restore |
| fix_tag | input | TW | Tag written by the restore |

## Verification
The bench builds the block with its defaults: 8 architectural and 32 physical registers. This gives a pool of 24 tags, so a run of a few dozen renames drains the free list completely. That brings the DRAIN and REFILL transitions within reach, along with a release arriving while the list is empty and a release paired with an allocation when only one tag is left. The small table also lets short vectors revisit the same register to exercise overwrites and same-instruction source/destination overlap.

// File: rtl/rn_pkg.sv
package rn_pkg;
    typedef enum logic [0:0] {
        ST_FLOWING = 1'b0,
        ST_STARVED = 1'b1
    } pool_state_e;
endpackage

// File: rtl/rn_alias_table.sv
module rn_alias_table #(
    parameter int NUM_ARCH = 8,
    parameter int NUM_PHYS = 32,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int TW = $clog2(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a_idx,
    input  logic [AW-1:0] rd_b_idx,
    input  logic [AW-1:0] rd_c_idx,
    output logic [TW-1:0] rd_a_tag,
    output logic [TW-1:0] rd_b_tag,
    output logic [TW-1:0] rd_c_tag,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [TW-1:0] wr_tag
);
    logic [TW-1:0] map_q [NUM_ARCH];

    for (genvar gi = 0; gi < NUM_ARCH; gi++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                map_q[gi] <= TW'(gi);
            end else if (wr_en && (wr_idx == AW'(gi))) begin
                map_q[gi] <= wr_tag;
            end
        end
    end

    assign rd_a_tag = map_q[rd_a_idx];
    assign rd_b_tag = map_q[rd_b_idx];
    assign rd_c_tag = map_q[rd_c_idx];

    // R4
    table_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> map_q[$past(wr_idx)] == $past(wr_tag));
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
    parameter int NUM_ARCH = 8,
    parameter int NUM_PHYS = 32,
    localparam int TW    = $clog2(NUM_PHYS),
    localparam int DEPTH = NUM_PHYS,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int INIT  = NUM_PHYS - NUM_ARCH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [TW-1:0] push_tag,
    output logic [TW-1:0] head_tag,
    output logic [CW-1:0] level
);
    logic [TW-1:0] slot_q [DEPTH];
    logic [PW-1:0] rd_ptr_q, wr_ptr_q;
    logic [CW-1:0] level_q;

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[gi] <= (gi < INIT) ? TW'(NUM_ARCH + gi) : '0;
            end else if (push && (wr_ptr_q == PW'(gi))) begin
                slot_q[gi] <= push_tag;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= PW'(INIT);
            level_q  <= CW'(INIT);
        end else begin
            if (pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
            if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
            level_q <= level_q + CW'(push) - CW'(pop);
        end
    end

    assign head_tag = slot_q[rd_ptr_q];
    assign level    = level_q;

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> level_q != '0);
    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> level_q < CW'(DEPTH));
endmodule

// File: rtl/rn_rename_map.sv
module rn_rename_map
    import rn_pkg::*;
#(
    parameter int NUM_ARCH = 8,
    parameter int NUM_PHYS = 32,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int TW = $clog2(NUM_PHYS),
    localparam int CW = $clog2(NUM_PHYS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW-1:0] in_src_a,
    input  logic [AW-1:0] in_src_b,
    input  logic          in_dst_en,
    input  logic [AW-1:0] in_dst,
    output logic          in_ready,
    output logic [TW-1:0] out_src_a_tag,
    output logic [TW-1:0] out_src_b_tag,
    output logic [TW-1:0] out_new_tag,
    output logic [TW-1:0] out_old_tag,
    input  logic          free_valid,
    input  logic [TW-1:0] free_tag,
    input  logic          fix_valid,
    input  logic [AW-1:0] fix_arch,
    input  logic [TW-1:0] fix_tag
);
    pool_state_e   state_q, state_d;
    logic          alloc;
    logic          tbl_wr;
    logic [AW-1:0] tbl_idx;
    logic [TW-1:0] tbl_tag;
    logic [TW-1:0] head_tag;
    logic [CW-1:0] level, level_nxt;

    rn_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop      (alloc),
        .push     (free_valid),
        .push_tag (free_tag),
        .head_tag (head_tag),
        .level    (level)
    );

    rn_alias_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (in_src_a),
        .rd_b_idx (in_src_b),
        .rd_c_idx (in_dst),
        .rd_a_tag (out_src_a_tag),
        .rd_b_tag (out_src_b_tag),
        .rd_c_tag (out_old_tag),
        .wr_en    (tbl_wr),
        .wr_idx   (tbl_idx),
        .wr_tag   (tbl_tag)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FLOWING;
        else        state_q <= state_d;
    end

    // next-state and outputs
    always_comb begin
        in_ready  = 1'b0;
        level_nxt = level + CW'(free_valid) - CW'(alloc);
        state_d   = state_q;
        unique case (state_q)
            ST_FLOWING: begin
                in_ready = !fix_valid;
                if (level_nxt == '0) state_d = ST_STARVED;   // DRAIN
            end
            ST_STARVED: begin
                in_ready = 1'b0;
                if (free_valid) state_d = ST_FLOWING;        // REFILL
            end
            default: state_d = ST_FLOWING;
        endcase
    end

    assign alloc       = in_valid && in_ready && in_dst_en;
    assign out_new_tag = head_tag;
    assign tbl_wr      = fix_valid || alloc;
    assign tbl_idx     = fix_valid ? fix_arch : in_dst;
    assign tbl_tag     = fix_valid ? fix_tag  : head_tag;

    // R3
    fresh_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> out_new_tag != out_old_tag);
    // R7
    starved_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STARVED) |-> (level == '0 && !in_ready));
    // R9
    fix_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fix_valid |-> !in_ready);
    // R6
    no_dst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_dst_en && !fix_valid && !free_valid)
            |=> $stable(level));
endmodule

// File: tb/rn_rename_map_tb.sv
module rn_rename_map_tb;
    localparam int NA = 8;
    localparam int NP = 32;
    localparam int AW = 3;
    localparam int TW = 5;
    localparam int NV = 6;

    // {src_a, src_b, dst_en, dst, exp_a, exp_b, exp_new, exp_old}
    localparam logic [29:0] VEC [NV] = '{
        {3'd2, 3'd3, 1'b1, 3'd1, 5'd2,  5'd3, 5'd8,  5'd1},
        {3'd1, 3'd5, 1'b1, 3'd4, 5'd8,  5'd5, 5'd9,  5'd4},
        {3'd6, 3'd7, 1'b1, 3'd1, 5'd6,  5'd7, 5'd10, 5'd8},
        {3'd1, 3'd0, 1'b1, 3'd0, 5'd10, 5'd0, 5'd11, 5'd0},
        {3'd0, 3'd4, 1'b0, 3'd2, 5'd11, 5'd9, 5'd12, 5'd2},
        {3'd2, 3'd1, 1'b1, 3'd2, 5'd2,  5'd10, 5'd12, 5'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_dst_en = 1'b0;
    logic [AW-1:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
    logic in_ready;
    logic [TW-1:0] out_src_a_tag, out_src_b_tag, out_new_tag, out_old_tag;
    logic free_valid = 1'b0, fix_valid = 1'b0;
    logic [TW-1:0] free_tag = '0, fix_tag = '0;
    logic [AW-1:0] fix_arch = '0;
    int errors = 0, checks = 0;

    always #2 clk = ~clk;

    rn_rename_map #(.NUM_ARCH(NA), .NUM_PHYS(NP)) u_dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [AW-1:0] a, input logic [AW-1:0] b,
                         input logic de, input logic [AW-1:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_src_a = a; in_src_b = b; in_dst_en = de; in_dst = d;
        #1;
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        drive(3'd5, 3'd7, 1'b0, 3'd0);
        chk("R1 ready", in_ready, 1);
        chk("R1 map5", out_src_a_tag, 5);
        chk("R1 map7", out_src_b_tag, 7);
        chk("R1 head", out_new_tag, NA);
        // vector walk: R2 R3 R4 R5 R6 R10
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][29:27], VEC[i][26:24], VEC[i][23], VEC[i][22:20]);
            chk("R2/R4/R10 src_a", out_src_a_tag, int'(VEC[i][19:15]));
            chk("R2/R4 src_b", out_src_b_tag, int'(VEC[i][14:10]));
            chk("R3/R6 new", out_new_tag, int'(VEC[i][9:5]));
            chk("R5 old", out_old_tag, int'(VEC[i][4:0]));
        end
        // drain remaining 19 tags (13..31) on register 3
        for (int t = 13; t < NP; t++) begin
            drive(3'd0, 3'd0, 1'b1, 3'd3);
            chk("R3 drain alloc", out_new_tag, t);
            chk("R3 drain ready", in_ready, 1);
        end
        drive(3'd3, 3'd5, 1'b1, 3'd5);
        chk("R4 last alloc visible", out_src_a_tag, 31);
        chk("R7 stalled when empty", in_ready, 0);
        drive(3'd5, 3'd0, 1'b1, 3'd5);
        chk("R7 no apply while stalled", out_src_a_tag, 5);
        // R8: release while empty still stalls this cycle
        free_valid = 1'b1; free_tag = 5'd4;
        chk("R8 stall with release into empty", in_ready, 0);
        drive(3'd0, 3'd0, 1'b1, 3'd6);
        free_tag = 5'd0;
        chk("R7 refill ready", in_ready, 1);
        chk("R7 released tag reused", out_new_tag, 4);
        chk("R5 old of r6", out_old_tag, 6);
        // R8: release 0 and allocate 4 in same cycle; level stays one
        drive(3'd6, 3'd0, 1'b1, 3'd7);
        free_valid = 1'b0;
        chk("R8 ready after paired op", in_ready, 1);
        chk("R8 released tag at head", out_new_tag, 0);
        chk("R4 r6 mapped", out_src_a_tag, 4);
        // R9: restore blocks rename
        fix_valid = 1'b1; fix_arch = 3'd1; fix_tag = 5'd7;
        drive(3'd1, 3'd1, 1'b1, 3'd1);
        chk("R9 ready low on restore", in_ready, 0);
        drive(3'd1, 3'd7, 1'b1, 3'd1);
        fix_valid = 1'b0;
        #1;
        chk("R9 restored entry", out_src_a_tag, 7);
        chk("R9 rename not applied", out_new_tag, 0);
        chk("R9 ready restored", in_ready, 1);
        @(negedge clk);
        in_valid = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule